// File: doc/BRIEF.md
# Load-Use and Branch Stall Monitor

This block observes the instruction stream as it retires from an in-order core and accounts for the cycles the pipeline loses. Each retiring instruction arrives with its unit class, up to two source register numbers, each with a valid flag, a load destination register, a branch-taken flag, and flags for the first and last instruction of an issue group. A group is one instruction or a parallel pair.

Registers written by loads are collected in a pending mask while a group retires. When the group's last instruction retires, the pending mask becomes the hazard mask. The instructions of the next group compare their sources against that hazard mask, and each hit costs two cycles. A taken branch costs two cycles. Taken and not-taken branches are also counted. All counters saturate, so a long run never wraps to a small value.

Top module: `stall_monitor`

## Requirements
- R1: After reset all four counters read zero, and the pending and hazard masks read zero.
- R2: A retiring load (unit code 4) sets the bit of its destination register in the pending mask. A load that is not the last of its group leaves that bit visible on the pending mask output.
- R3: When the last instruction of a group retires, the pending mask, including that instruction's own load, is copied to the hazard mask, and the pending mask is cleared.
- R4: An instruction flagged first starts from an empty pending mask, so load bits left by an unterminated earlier group are discarded.
- R5: The exec, compare and multiply-accumulate classes (unit codes 0, 1, 2) check both source registers. Each valid source whose bit is set in the hazard mask adds 2 to the load-stall counter.
- R6: The branch class (unit code 3) checks only source A. Source B never causes a stall for a branch.
- R7: Loads and stores (unit codes 4 and 5) check no sources and never add to the load-stall counter.
- R8: A source whose valid flag is low never causes a stall, even when its register number hits the hazard mask.
- R9: A taken branch adds 2 to the branch-stall counter and 1 to the taken count. A not-taken branch adds 1 to the not-taken count. The taken flag has no effect on other classes.
- R10: Each counter saturates at its all-ones value and stays there.
- R11: While the retire-valid input is low, no counter or mask changes.
- R12: Every instruction of a group checks the hazard mask from before the group. A load in the first slot of a pair does not stall the second slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| unit_i | input | 3 | Unit class: 0 exec, 1 compare, 2 mac, 3 branch, 4 load, 5 store |
| src_a_valid_i | input | 1 | Source A is present |
| src_a_i | input | IDX_W (4) | Source A register number |
| src_b_valid_i | input | 1 | Source B is present |
| src_b_i | input | IDX_W (4) | Source B register number |
| dest_i | input | IDX_W (4) | Load destination register |
| taken_i | input | 1 | The branch was taken |
| first_i | input | 1 | First instruction of an issue group |
| last_i | input | 1 | Last instruction of an issue group |
| load_stall_o | output | CNT_W (32) | Load-use stall cycles |
| branch_stall_o | output | CNT_W (32) | Taken-branch stall cycles |
| taken_cnt_o | output | CNT_W (32) | Taken branches |
| untaken_cnt_o | output | CNT_W (32) | Not-taken branches |
| pending_mask_o | output | NUM_REGS (16) | Loads of the group now retiring |
| hazard_mask_o | output | NUM_REGS (16) | Loads of the previous group |

## Verification
The main sweep retires a load to every register and follows it with an exec whose two sources walk every register. This shows that a hit lands only on the exact register and that two hits add four. The same load-then-consumer pattern is repeated with each unit class and each combination of valid flags, which separates the two-source, one-source and no-source classes and shows that the valid flags gate hits. Paired groups and groups with no last flag show when the pending mask is handed over or discarded. Long runs of hits and taken branches drive the counters into saturation.

// File: rtl/stall_pkg.sv
package stall_pkg;
  typedef enum logic [2:0] {
    UNIT_EXEC   = 3'd0,
    UNIT_CMP    = 3'd1,
    UNIT_MAC    = 3'd2,
    UNIT_BRANCH = 3'd3,
    UNIT_LOAD   = 3'd4,
    UNIT_STORE  = 3'd5
  } unit_e;

  localparam int unsigned STALL_PENALTY = 2;
endpackage

// File: rtl/stall_hazard_check.sv
module stall_hazard_check #(
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  stall_pkg::unit_e    unit_i,
  input  logic                a_valid_i,
  input  logic [IDX_W-1:0]    a_i,
  input  logic                b_valid_i,
  input  logic [IDX_W-1:0]    b_i,
  input  logic [NUM_REGS-1:0] mask_i,
  output logic [2:0]          cycles_o
);
  import stall_pkg::*;

  logic use_a, use_b, hit_a, hit_b;

  always_comb begin
    unique case (unit_i)
      UNIT_EXEC, UNIT_CMP, UNIT_MAC: begin use_a = 1'b1; use_b = 1'b1; end
      UNIT_BRANCH:                   begin use_a = 1'b1; use_b = 1'b0; end
      default:                       begin use_a = 1'b0; use_b = 1'b0; end
    endcase
    hit_a    = use_a && a_valid_i && mask_i[a_i];
    hit_b    = use_b && b_valid_i && mask_i[b_i];
    // two cycles per hit: 0, 2 or 4
    cycles_o = {hit_a && hit_b, hit_a ^ hit_b, 1'b0};
  end
endmodule

// File: rtl/stall_load_tracker.sv
module stall_load_tracker #(
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                is_load_i,
  input  logic [IDX_W-1:0]    dest_i,
  input  logic                first_i,
  input  logic                last_i,
  output logic [NUM_REGS-1:0] pend_o,
  output logic [NUM_REGS-1:0] cur_o
);
  logic [NUM_REGS-1:0] pend_q, cur_q, pend_next;

  always_comb begin
    pend_next = first_i ? '0 : pend_q;
    if (is_load_i) pend_next[dest_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      cur_q  <= '0;
    end else if (valid_i) begin
      if (last_i) begin
        cur_q  <= pend_next;
        pend_q <= '0;
      end else begin
        pend_q <= pend_next;
      end
    end
  end

  assign pend_o = pend_q;
  assign cur_o  = cur_q;

  p_pend_cleared_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> (pend_q == '0));

  p_load_marked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_load_i && !last_i) |=> ((pend_q & (NUM_REGS'(1) << $past(dest_i))) != '0));

  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(pend_q) && $stable(cur_q)));
endmodule

// File: rtl/stall_sat_counter.sv
module stall_sat_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (sum[CNT_W])     cnt_q <= '1;
    else                     cnt_q <= sum[CNT_W-1:0];
  end

  assign count_o = cnt_q;

  p_sat_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1) |=> (cnt_q == '1));

  p_no_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/stall_monitor.sv
module stall_monitor #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned CNT_W    = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                retire_valid_i,
  input  logic [2:0]          unit_i,
  input  logic                src_a_valid_i,
  input  logic [IDX_W-1:0]    src_a_i,
  input  logic                src_b_valid_i,
  input  logic [IDX_W-1:0]    src_b_i,
  input  logic [IDX_W-1:0]    dest_i,
  input  logic                taken_i,
  input  logic                first_i,
  input  logic                last_i,
  output logic [CNT_W-1:0]    load_stall_o,
  output logic [CNT_W-1:0]    branch_stall_o,
  output logic [CNT_W-1:0]    taken_cnt_o,
  output logic [CNT_W-1:0]    untaken_cnt_o,
  output logic [NUM_REGS-1:0] pending_mask_o,
  output logic [NUM_REGS-1:0] hazard_mask_o
);
  import stall_pkg::*;

  localparam int unsigned NUM_CNT = 4;
  localparam int unsigned INC_W   = 3;

  unit_e            unit;
  logic [2:0]       hit_cycles;
  logic             is_branch;
  logic [INC_W-1:0] inc [NUM_CNT];
  logic [CNT_W-1:0] cnt [NUM_CNT];

  assign unit      = unit_e'(unit_i);
  assign is_branch = retire_valid_i && (unit == UNIT_BRANCH);

  stall_load_tracker #(.NUM_REGS(NUM_REGS)) u_tracker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (retire_valid_i),
    .is_load_i (unit == UNIT_LOAD),
    .dest_i    (dest_i),
    .first_i   (first_i),
    .last_i    (last_i),
    .pend_o    (pending_mask_o),
    .cur_o     (hazard_mask_o)
  );

  stall_hazard_check #(.NUM_REGS(NUM_REGS)) u_check (
    .unit_i    (unit),
    .a_valid_i (src_a_valid_i),
    .a_i       (src_a_i),
    .b_valid_i (src_b_valid_i),
    .b_i       (src_b_i),
    .mask_i    (hazard_mask_o),
    .cycles_o  (hit_cycles)
  );

  // 0 load stall, 1 branch stall, 2 taken, 3 not taken
  assign inc[0] = retire_valid_i ? hit_cycles : '0;
  assign inc[1] = (is_branch && taken_i)  ? INC_W'(STALL_PENALTY) : '0;
  assign inc[2] = (is_branch && taken_i)  ? INC_W'(1) : '0;
  assign inc[3] = (is_branch && !taken_i) ? INC_W'(1) : '0;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    stall_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc[i]),
      .count_o (cnt[i])
    );
  end

  assign load_stall_o   = cnt[0];
  assign branch_stall_o = cnt[1];
  assign taken_cnt_o    = cnt[2];
  assign untaken_cnt_o  = cnt[3];

  p_no_src_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_valid_i && (unit_i == 3'd4 || unit_i == 3'd5)) |=> $stable(load_stall_o));

  p_branch_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_valid_i && unit_i != 3'd3) |=>
      ($stable(branch_stall_o) && $stable(taken_cnt_o) && $stable(untaken_cnt_o)));

  p_idle_counters_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_valid_i |=> ($stable(load_stall_o) && $stable(branch_stall_o)
                         && $stable(taken_cnt_o) && $stable(untaken_cnt_o)));

  p_invalid_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_valid_i && !src_a_valid_i && !src_b_valid_i) |=> $stable(load_stall_o));
endmodule

// File: tb/sim_stall_monitor.sv
module sim_stall_monitor;
  localparam int NR = 16;
  localparam int CW = 10;
  localparam int MAXV = (1 << CW) - 1;
  localparam int U_EXEC = 0, U_CMP = 1, U_MAC = 2, U_BR = 3, U_LD = 4, U_ST = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [2:0] unit = '0;
  logic av = 1'b0, bv = 1'b0, tk = 1'b0, fst = 1'b0, lst = 1'b0;
  logic [3:0] a = '0, b = '0, d = '0;
  logic [CW-1:0] ls_o, bs_o, tc_o, uc_o;
  logic [NR-1:0] pm_o, hm_o;

  int checks = 0, fails = 0;
  int e_ls = 0, e_bs = 0, e_tc = 0, e_uc = 0;
  logic [NR-1:0] e_pm = '0, e_hm = '0;

  always #2 clk = ~clk;

  stall_monitor #(.NUM_REGS(NR), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .retire_valid_i(valid), .unit_i(unit),
    .src_a_valid_i(av), .src_a_i(a), .src_b_valid_i(bv), .src_b_i(b),
    .dest_i(d), .taken_i(tk), .first_i(fst), .last_i(lst),
    .load_stall_o(ls_o), .branch_stall_o(bs_o), .taken_cnt_o(tc_o),
    .untaken_cnt_o(uc_o), .pending_mask_o(pm_o), .hazard_mask_o(hm_o));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "load_stall", int'(ls_o), e_ls);
    chk(req, "branch_stall", int'(bs_o), e_bs);
    chk(req, "taken", int'(tc_o), e_tc);
    chk(req, "untaken", int'(uc_o), e_uc);
    chk(req, "pending", int'(pm_o), int'(e_pm));
    chk(req, "hazard", int'(hm_o), int'(e_hm));
  endtask

  function automatic int sat(int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic issue(string req, bit vl, int u, bit iav, int ia, bit ibv, int ib,
                       int id, bit itk, bit ifst, bit ilst);
    int hits;
    logic [NR-1:0] p;
    @(negedge clk);
    valid = vl; unit = 3'(u); av = iav; a = 4'(ia); bv = ibv; b = 4'(ib);
    d = 4'(id); tk = itk; fst = ifst; lst = ilst;
    if (vl) begin
      hits = 0;
      if (u <= U_MAC) hits = int'(iav && e_hm[ia]) + int'(ibv && e_hm[ib]);
      else if (u == U_BR) hits = int'(iav && e_hm[ia]);
      e_ls = sat(e_ls + 2 * hits);
      if (u == U_BR) begin
        if (itk) begin e_bs = sat(e_bs + 2); e_tc = sat(e_tc + 1); end
        else e_uc = sat(e_uc + 1);
      end
      p = ifst ? '0 : e_pm;
      if (u == U_LD) p[id] = 1'b1;
      if (ilst) begin e_hm = p; e_pm = '0; end
      else e_pm = p;
    end
    @(posedge clk);
    #1;
    check_all(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0;
    e_ls = 0; e_bs = 0; e_tc = 0; e_uc = 0; e_pm = '0; e_hm = '0;
    #7;
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();

    // R2 R3 R5: load to each register, exec sweeps sources
    for (int rd = 0; rd < NR; rd++)
      for (int s = 0; s < NR; s++) begin
        issue("R2", 1, U_LD, 0, 0, 0, 0, rd, 0, 1, 1);
        issue("R5", 1, U_EXEC, 1, s, 1, (s + 1) % NR, 0, 0, 1, 1);
      end
    // R5: double hit adds four
    issue("R2", 1, U_LD, 0, 0, 0, 0, 9, 0, 1, 1);
    issue("R5", 1, U_EXEC, 1, 9, 1, 9, 0, 0, 1, 1);

    // each class with every valid combination: R5 R6 R7 R8
    for (int u = 0; u < 6; u++)
      for (int vm = 0; vm < 4; vm++) begin
        issue("R2", 1, U_LD, 0, 0, 0, 0, 6, 0, 1, 1);
        issue((u <= U_MAC) ? "R5" : (u == U_BR) ? "R6" : "R7",
              1, u, vm[0], 6, vm[1], 6, 2, 0, 1, 1);
      end
    issue("R2", 1, U_LD, 0, 0, 0, 0, 11, 0, 1, 1);
    issue("R8", 1, U_MAC, 0, 11, 0, 11, 0, 0, 1, 1);

    // R9: taken and not-taken branches, taken flag on other classes
    issue("R9", 1, U_BR, 0, 0, 0, 0, 0, 1, 1, 1);
    issue("R9", 1, U_BR, 0, 0, 0, 0, 0, 0, 1, 1);
    issue("R9", 1, U_EXEC, 0, 0, 0, 0, 0, 1, 1, 1);
    issue("R9", 1, U_ST, 0, 0, 0, 0, 0, 1, 1, 1);

    // R2 R3 R12: pair with load in first slot
    issue("R2", 1, U_LD, 0, 0, 0, 0, 7, 0, 1, 0);
    issue("R12", 1, U_EXEC, 1, 7, 0, 0, 0, 0, 0, 1);
    issue("R3", 1, U_EXEC, 1, 7, 0, 0, 0, 0, 1, 1);
    // R3: last instruction's own load reaches hazard mask
    issue("R2", 1, U_LD, 0, 0, 0, 0, 1, 0, 1, 0);
    issue("R3", 1, U_LD, 0, 0, 0, 0, 2, 0, 0, 1);
    issue("R3", 1, U_CMP, 1, 1, 1, 2, 0, 0, 1, 1);

    // R4: unterminated group discarded by next first
    issue("R2", 1, U_LD, 0, 0, 0, 0, 3, 0, 1, 0);
    issue("R4", 1, U_LD, 0, 0, 0, 0, 5, 0, 1, 1);
    issue("R4", 1, U_EXEC, 1, 3, 1, 5, 0, 0, 1, 1);

    // R11: retire_valid low changes nothing
    issue("R2", 1, U_LD, 0, 0, 0, 0, 4, 0, 1, 1);
    issue("R2", 1, U_LD, 0, 0, 0, 0, 8, 0, 1, 0);
    issue("R11", 0, U_LD, 1, 4, 1, 4, 12, 1, 1, 1);
    issue("R11", 0, U_BR, 1, 4, 1, 4, 0, 1, 1, 1);
    issue("R11", 0, U_EXEC, 1, 4, 1, 4, 0, 0, 1, 1);

    // R10: saturation
    do_reset();
    for (int i = 0; i < 270; i++) begin
      issue("R10", 1, U_LD, 0, 0, 0, 0, 13, 0, 1, 1);
      issue("R10", 1, U_MAC, 1, 13, 1, 13, 0, 0, 1, 1);
    end
    for (int i = 0; i < 520; i++) issue("R10", 1, U_BR, 0, 0, 0, 0, 0, 1, 1, 1);
    for (int i = 0; i < 1030; i++) issue("R10", 1, U_BR, 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R10", "load_stall max", int'(ls_o), MAXV);
    chk("R10", "taken max", int'(tc_o), 520);
    chk("R10", "untaken max", int'(uc_o), MAXV);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule